// File: doc/BRIEF.md
# AC'97 Transmit Channel FIFO

This block is one transmit channel of an AC'97 controller. Software pushes 32-bit words into a small FIFO through a register-style write port. The same port carries three more registers: a channel control word, an interrupt-enable word and a write-one-to-clear word. At every frame boundary the serial frame formatter pulses `frame_start_i`. The channel then walks the six PCM slots it can feed and hands one 20-bit sample to the formatter for each slot that is enabled.

Samples come in two packings. In normal packing each FIFO word holds one sample. In compact packing each word holds two 16-bit samples, the low half first. If the FIFO is empty when a slot needs a sample, the slot receives zero and the channel latches an underrun. Its status flags (empty, half-empty, full, busy, underrun) drive a 7-bit interrupt field. That field is merged into a 28-bit interrupt word shared by four channels.

Clearing the transmit-enable bit keeps the queued words. Only dropping the interface-enable input flushes them.

Top module: `ac97_tx_chan`

## Requirements
- R1: After reset the status reads empty=1, half-empty=1, full=0, busy=0, underrun=0 (stat_o = 5'b00011), slot_vld_o is 0 and the own interrupt field is 0.
- R2: A write with reg_sel_i=0 enters the FIFO only when control bit 1 (FIFO enable) is set, if_en_i is high and the FIFO holds fewer than DEPTH words; a write while full is discarded.
- R3: stat_o bit 0 (empty) is set when no word is stored, bit 1 (half-empty) when at most DEPTH/2 words are stored, bit 2 (full) when DEPTH words are stored.
- R4: A frame_start_i pulse sampled while no walk is running starts a walk over slot positions for slots 3,4,6,7,8,9 in that order, one per cycle, the first result appearing after the next clock edge. A slot is served (slot_vld_o=1, slot_id_o = slot number) only when control bit 0 (transmit enable), bit 1 and its slot-enable bit are set; control bits 4..9 enable slots 3,4,6,7,8,9 respectively.
- R5: In normal packing (control bit 2 clear) each served slot pops one word; with control bit 3 set the sample is word[15:0] followed by four zero bits, otherwise it is word[19:0].
- R6: In compact packing (control bit 2 set) a served slot takes the low half-word first, then the high half-word; the word is popped after its high half; the sample is the half-word followed by four zero bits.
- R7: A served slot that finds the FIFO empty gets sample 0 with slot_vld_o=1 and sets the underrun flag (stat_o bit 4); writing reg_sel_i=3 with bit CHAN set clears it, and a new underrun in the same cycle wins.
- R8: The own interrupt field at bits 7*CHAN+6..7*CHAN holds bit 0 = half-empty AND interrupt-enable bit 0, bit 1 = underrun AND interrupt-enable bit 1, other bits 0; it is ORed with other_irq_i, which otherwise passes through to irq_all_o; irq_o is the OR of irq_all_o.
- R9: Clearing the transmit-enable bit leaves stored words in place; while if_en_i is low the FIFO and the compact half pointer are cleared.
- R10: stat_o bit 3 (busy) is set when transmit enable is set and the FIFO is non-empty or a frame walk is running.
- R11: A frame_start_i pulse that arrives while a walk is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en_i | input | 1 | Interface enable; low flushes the FIFO |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 data, 1 control, 2 interrupt enable, 3 clear |
| reg_wdata_i | input | 32 | Write data |
| frame_start_i | input | 1 | Frame boundary pulse from the formatter |
| other_irq_i | input | 28 | Interrupt fields of the other channels |
| stat_o | output | 5 | {underrun, busy, full, half-empty, empty} |
| irq_all_o | output | 28 | Combined four-channel interrupt word |
| irq_o | output | 1 | OR of irq_all_o |
| slot_vld_o | output | 1 | Sample valid for the formatter |
| slot_id_o | output | 4 | Slot number of the sample |
| slot_dat_o | output | 20 | Slot sample |

## Verification
A frame pulse sampled at edge k yields the sample for walk position p after edge k+1+p, so a whole frame settles six edges after the pulse. The FIFO flags and busy follow one edge after a data write, a control write or a pop. The interrupt word is combinational from the registered flags and from other_irq_i, so it changes in the same cycle as they do. The bench updates its queue model at each rising edge from inputs driven two time units after the previous edge, and it compares every output at the falling edge, so each result is sampled in the cycle it is due.

// File: rtl/ac97tx_pkg.sv
package ac97tx_pkg;

    localparam int NUM_PCM_SLOTS = 6;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_IE   = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    // control word, LSB first: tx_en, fifo_en, compact, sz16, slot enables
    typedef struct packed {
        logic [NUM_PCM_SLOTS-1:0] slot_en;
        logic                     sz16;
        logic                     compact;
        logic                     fifo_en;
        logic                     tx_en;
    } tx_ctrl_t;

    typedef struct packed {
        logic ur_ie;
        logic tx_ie;
    } irq_en_t;

    // walk position to PCM slot number, ascending
    function automatic logic [3:0] slot_number(input logic [2:0] pos);
        case (pos)
            3'd0:    return 4'd3;
            3'd1:    return 4'd4;
            3'd2:    return 4'd6;
            3'd3:    return 4'd7;
            3'd4:    return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/ac97tx_fifo.sv
module ac97tx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          half_empty,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[st_q.wp] <= wdata;
    end

    assign rdata      = mem_q[st_q.rp];
    assign empty      = (st_q.cnt == '0);
    assign full       = (st_q.cnt == CW'(DEPTH));
    assign half_empty = (st_q.cnt <= CW'(DEPTH / 2));

endmodule

// File: rtl/ac97tx_slot_seq.sv
module ac97tx_slot_seq
    import ac97tx_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          frame_start,
    input  tx_ctrl_t      ctrl,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_word,
    output logic          fifo_pop,
    output logic          walking,
    output logic          ur_evt,
    output logic          slot_vld,
    output logic [3:0]    slot_id,
    output logic [SW-1:0] slot_dat
);
    localparam int HW   = DW / 2;
    localparam int PAD  = SW - 16;
    localparam logic [2:0] LAST = 3'(NUM_PCM_SLOTS - 1);

    typedef struct packed {
        logic          walk;
        logic [2:0]    pos;
        logic          hsel;
        logic          vld;
        logic [3:0]    id;
        logic [SW-1:0] dat;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic          serve;
    logic [HW-1:0] half;

    always_comb begin
        st_d     = st_q;
        fifo_pop = 1'b0;
        ur_evt   = 1'b0;
        st_d.vld = 1'b0;
        st_d.id  = '0;
        st_d.dat = '0;
        serve    = st_q.walk && ctrl.tx_en && ctrl.fifo_en && ctrl.slot_en[st_q.pos];
        half     = st_q.hsel ? fifo_word[DW-1:HW] : fifo_word[HW-1:0];
        if (serve) begin
            st_d.vld = 1'b1;
            st_d.id  = slot_number(st_q.pos);
            if (fifo_empty) begin
                ur_evt = 1'b1;
            end else if (ctrl.compact) begin
                st_d.dat  = {half[15:0], {PAD{1'b0}}};
                st_d.hsel = !st_q.hsel;
                fifo_pop  = st_q.hsel;
            end else begin
                fifo_pop = 1'b1;
                st_d.dat = ctrl.sz16 ? {fifo_word[15:0], {PAD{1'b0}}} : fifo_word[SW-1:0];
            end
        end
        if (st_q.walk) begin
            if (st_q.pos == LAST) st_d.walk = 1'b0;
            else                  st_d.pos  = st_q.pos + 1'b1;
        end else if (frame_start) begin
            st_d.walk = 1'b1;
            st_d.pos  = '0;
        end
        if (flush) st_d.hsel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign walking  = st_q.walk;
    assign slot_vld = st_q.vld;
    assign slot_id  = st_q.id;
    assign slot_dat = st_q.dat;

endmodule

// File: rtl/ac97_tx_chan.sv
module ac97_tx_chan
    import ac97tx_pkg::*;
#(
    parameter int CHAN  = 0,
    parameter int DEPTH = 8,
    parameter int NCH   = 4,
    parameter int IRQ_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 if_en_i,
    input  logic                 reg_we_i,
    input  logic [1:0]           reg_sel_i,
    input  logic [31:0]          reg_wdata_i,
    input  logic                 frame_start_i,
    input  logic [NCH*IRQ_W-1:0] other_irq_i,
    output logic [4:0]           stat_o,
    output logic [NCH*IRQ_W-1:0] irq_all_o,
    output logic                 irq_o,
    output logic                 slot_vld_o,
    output logic [3:0]           slot_id_o,
    output logic [19:0]          slot_dat_o
);
    localparam int CTRL_W = $bits(tx_ctrl_t);
    localparam int IE_W   = $bits(irq_en_t);

    typedef struct packed {
        tx_ctrl_t ctrl;
        irq_en_t  ie;
        logic     ur;
    } chan_st_t;

    chan_st_t    st_d, st_q;
    logic        flush, push, pop, ur_evt, walking;
    logic        empty, half_empty, full;
    logic [31:0] head;
    logic [IRQ_W-1:0] own_irq;

    assign flush = !if_en_i;
    assign push  = reg_we_i && (reg_sel_i == SEL_DATA) && st_q.ctrl.fifo_en && if_en_i;

    always_comb begin
        st_d = st_q;
        if (reg_we_i && reg_sel_i == SEL_CTRL) st_d.ctrl = tx_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        if (reg_we_i && reg_sel_i == SEL_IE)   st_d.ie   = irq_en_t'(reg_wdata_i[IE_W-1:0]);
        if (ur_evt)                                                    st_d.ur = 1'b1;
        else if (reg_we_i && reg_sel_i == SEL_CLR && reg_wdata_i[CHAN]) st_d.ur = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ac97tx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wdata(reg_wdata_i),
        .pop(pop), .rdata(head), .empty(empty), .half_empty(half_empty), .full(full)
    );

    ac97tx_slot_seq #(.DW(32), .SW(20)) u_seq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .frame_start(frame_start_i),
        .ctrl(st_q.ctrl), .fifo_empty(empty), .fifo_word(head), .fifo_pop(pop),
        .walking(walking), .ur_evt(ur_evt), .slot_vld(slot_vld_o),
        .slot_id(slot_id_o), .slot_dat(slot_dat_o)
    );

    assign stat_o  = {st_q.ur, st_q.ctrl.tx_en && (!empty || walking), full, half_empty, empty};
    assign own_irq = {{(IRQ_W-2){1'b0}}, st_q.ur && st_q.ie.ur_ie, half_empty && st_q.ie.tx_ie};

    for (genvar c = 0; c < NCH; c++) begin : g_irq
        if (c == CHAN) begin : g_own
            assign irq_all_o[c*IRQ_W +: IRQ_W] = other_irq_i[c*IRQ_W +: IRQ_W] | own_irq;
        end else begin : g_pass
            assign irq_all_o[c*IRQ_W +: IRQ_W] = other_irq_i[c*IRQ_W +: IRQ_W];
        end
    end

    assign irq_o = |irq_all_o;

endmodule

// File: rtl/ac97_tx_chan_chk.sv
module ac97_tx_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        if_en_i,
    input logic        reg_we_i,
    input logic [1:0]  reg_sel_i,
    input logic [4:0]  stat_o,
    input logic        slot_vld_o,
    input logic [3:0]  slot_id_o,
    input logic [19:0] slot_dat_o
);
    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_o[2] && stat_o[0]));

    // R2
    full_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[2]) |-> $past(reg_we_i && reg_sel_i == 2'd0));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en_i |=> stat_o[0]);

    // R7
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[4]) |-> (slot_vld_o && slot_dat_o == 20'd0));

    // R4
    slot_id_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_o |-> (slot_id_o inside {4'd3, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9}));

endmodule

bind ac97_tx_chan ac97_tx_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .if_en_i(if_en_i), .reg_we_i(reg_we_i),
    .reg_sel_i(reg_sel_i), .stat_o(stat_o), .slot_vld_o(slot_vld_o),
    .slot_id_o(slot_id_o), .slot_dat_o(slot_dat_o)
);

// File: tb/sim_ac97_tx_chan.sv
module sim_ac97_tx_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_en_i = 1'b1;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_sel_i = 2'd0;
    logic [31:0] reg_wdata_i = '0;
    logic        frame_start_i = 1'b0;
    logic [27:0] other_irq_i = '0;
    logic [4:0]  stat_o;
    logic [27:0] irq_all_o;
    logic        irq_o;
    logic        slot_vld_o;
    logic [3:0]  slot_id_o;
    logic [19:0] slot_dat_o;

    always #5 clk = ~clk;

    ac97_tx_chan u0 (
        .clk(clk), .rst_n(rst_n), .if_en_i(if_en_i), .reg_we_i(reg_we_i),
        .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .frame_start_i(frame_start_i),
        .other_irq_i(other_irq_i), .stat_o(stat_o), .irq_all_o(irq_all_o), .irq_o(irq_o),
        .slot_vld_o(slot_vld_o), .slot_id_o(slot_id_o), .slot_dat_o(slot_dat_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] q[$];
    bit          m_hsel, m_walk, m_ur;
    int          m_pos;
    logic [9:0]  m_ctrl;
    logic [1:0]  m_ie;
    bit          e_vld;
    logic [3:0]  e_id;
    logic [19:0] e_dat;
    int          ids[6] = '{3, 4, 6, 7, 8, 9};

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_hsel = 0; m_walk = 0; m_ur = 0; m_pos = 0;
            m_ctrl = '0; m_ie = '0; e_vld = 0; e_id = '0; e_dat = '0;
        end else begin : model
            bit acc, srv, urset;
            logic [31:0] w;
            logic [15:0] h;
            acc   = reg_we_i && reg_sel_i == 2'd0 && m_ctrl[1] && if_en_i && q.size() < 8;
            srv   = m_walk && m_ctrl[0] && m_ctrl[1] && m_ctrl[4 + m_pos];
            urset = 0; e_vld = 0; e_id = '0; e_dat = '0;
            if (srv) begin
                e_vld = 1; e_id = 4'(ids[m_pos]);
                if (q.size() == 0) urset = 1;
                else if (m_ctrl[2]) begin
                    w = q[0];
                    h = m_hsel ? w[31:16] : w[15:0];
                    e_dat = {h, 4'h0};
                    if (m_hsel) void'(q.pop_front());
                    m_hsel = !m_hsel;
                end else begin
                    w = q.pop_front();
                    e_dat = m_ctrl[3] ? {w[15:0], 4'h0} : w[19:0];
                end
            end
            if (m_walk) begin
                if (m_pos == 5) m_walk = 0; else m_pos++;
            end else if (frame_start_i) begin
                m_walk = 1; m_pos = 0;
            end
            if (acc) q.push_back(reg_wdata_i);
            if (!if_en_i) begin q.delete(); m_hsel = 0; end
            if (reg_we_i && reg_sel_i == 2'd1) m_ctrl = reg_wdata_i[9:0];
            if (reg_we_i && reg_sel_i == 2'd2) m_ie = reg_wdata_i[1:0];
            if (urset) m_ur = 1;
            else if (reg_we_i && reg_sel_i == 2'd3 && reg_wdata_i[0]) m_ur = 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin : cmp
            logic [2:0]  fl;
            logic [27:0] ei;
            fl = {q.size() == 8, q.size() <= 4, q.size() == 0};
            ei = other_irq_i | {21'd0, 5'd0, m_ur && m_ie[1], (q.size() <= 4) && m_ie[0]};
            chk(stat_o[2:0] == fl, "R3 flags", 32'(stat_o[2:0]), 32'(fl));
            chk(stat_o[3] == (m_ctrl[0] && (q.size() != 0 || m_walk)), "R10 busy",
                32'(stat_o[3]), 32'(m_ctrl[0] && (q.size() != 0 || m_walk)));
            chk(stat_o[4] == m_ur, "R7 underrun", 32'(stat_o[4]), 32'(m_ur));
            chk(slot_vld_o == e_vld && slot_id_o == e_id, "R4 slot", {slot_vld_o, slot_id_o},
                {e_vld, e_id});
            chk(slot_dat_o == e_dat, m_ctrl[2] ? "R6 compact data" : "R5 normal data",
                32'(slot_dat_o), 32'(e_dat));
            chk(irq_all_o == ei && irq_o == (|ei), "R8 irq", 32'(irq_all_o), 32'(ei));
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        @(posedge clk); #2;
        reg_we_i = 1'b0;
    endtask

    task automatic frame();
        @(posedge clk); #2 frame_start_i = 1'b1;
        @(posedge clk); #2 frame_start_i = 1'b0;
        repeat (8) @(posedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(stat_o == 5'b00011, "R1 stat", 32'(stat_o), 32'h3);
        chk(!slot_vld_o && irq_all_o == '0, "R1 outputs", {slot_vld_o, irq_all_o}, 32'h0);

        // R2 fill beyond depth, 16-bit normal, tx disabled
        wr(2'd1, 32'h0000_000A);
        for (int i = 0; i < 10; i++) wr(2'd0, 32'hA5A5_0000 + 32'(i * 32'h111));
        @(negedge clk);
        chk(stat_o[2] == 1'b1, "R2 full after overfill", 32'(stat_o[2]), 32'h1);

        // R4 R5 R7 R8 all slots, two frames, second runs dry
        wr(2'd2, 32'h3);
        wr(2'd1, 32'h0000_03FB);
        frame();
        frame();
        @(negedge clk);
        chk(stat_o[4] == 1'b1 && irq_o, "R7 underrun latched", 32'(stat_o), 32'h1X);
        wr(2'd3, 32'h0000_1FFF);
        @(negedge clk);
        chk(stat_o[4] == 1'b0, "R7 cleared", 32'(stat_o[4]), 32'h0);

        // R8 other channels pass through
        other_irq_i = 28'hABC_DE80;
        @(negedge clk);
        chk(irq_all_o[27:7] == 21'h15_79BD, "R8 pass", 32'(irq_all_o[27:7]), 32'h15_79BD);
        other_irq_i = '0;

        // R6 compact, slots 3,4,6
        wr(2'd1, 32'h0000_0077);
        wr(2'd0, 32'h1111_2222);
        wr(2'd0, 32'h3333_4444);
        wr(2'd0, 32'h5555_6666);
        frame();
        frame();
        @(negedge clk);
        chk(stat_o[0] == 1'b1, "R6 compact drained", 32'(stat_o[0]), 32'h1);

        // R5 20-bit normal, slot 7 only
        wr(2'd1, 32'h0000_0083);
        wr(2'd0, 32'hFFFA_BCDE);
        frame();

        // R9 tx disabled keeps data, interface low flushes
        wr(2'd1, 32'h0000_0002);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h3);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(stat_o[0] == 1'b0 && stat_o[3] == 1'b0, "R9 kept", 32'(stat_o), 32'h2);
        @(posedge clk); #2 if_en_i = 1'b0;
        @(posedge clk); #2 if_en_i = 1'b1;
        @(negedge clk);
        chk(stat_o[0] == 1'b1, "R9 flushed", 32'(stat_o[0]), 32'h1);

        // R11 second pulse during walk ignored
        wr(2'd1, 32'h0000_03FB);
        for (int i = 0; i < 8; i++) wr(2'd0, 32'h0000_1000 + 32'(i));
        @(posedge clk); #2 frame_start_i = 1'b1;
        @(posedge clk); #2 frame_start_i = 1'b0;
        @(posedge clk); #2 frame_start_i = 1'b1;
        @(posedge clk); #2 frame_start_i = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(stat_o[0] == 1'b0 && stat_o[4] == 1'b0, "R11 two words left", 32'(stat_o), 32'hA);
        chk(q.size() == 2, "R11 model count", 32'(q.size()), 32'h2);

        repeat (3) @(posedge clk);
        summary();
    end
endmodule